// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block sits on the controller side of an SDRAM interface. It starts when reset is released. It drives the command pins, the address bus and the bank select through the start-up routine that an SDRAM needs before normal use. When the routine is done it raises `ready_o`. After that the block drives idle commands only, and normal traffic belongs to the rest of the controller.

The routine has four steps:
- A quiet settling window, whose length is derived from the clock frequency and a wait time in microseconds.
- One precharge of all banks.
- A configurable number of auto-refresh commands.
- One write of the mode word.

A down-counter enforces a minimum spacing after each step. The precharge recovery, the refresh cycle time and the spacing after the mode write are all parameters. The mode word is assembled from separate parameters for burst length, wrap order, CAS latency and the upper option bits.

Top module: `sdram_init_seq`

## Requirements
- R1: For the first `WAIT_CYC = CLK_MHZ*WAIT_US` cycles after reset release (counting the release cycle), the command is NOP, `cke_o` is 1 and `ready_o` is 0. Commands are encoded on {cs_no,ras_no,cas_no,we_no}: NOP=0111, PRECHARGE=0010, REFRESH=0001, MODE SET=0000.
- R2: In cycle `WAIT_CYC`, a PRECHARGE is issued for exactly one cycle with `addr_o` = 14'h0400 (only bit 10 set, selecting all banks).
- R3: The command after the precharge comes exactly `T_RP` cycles after it, and every cycle in between is NOP.
- R4: Exactly `N_REF` REFRESH commands are issued (`N_REF` >= 8 by configuration), each `T_RFC` cycles after the previous one, with NOP in every cycle between them.
- R5: A single MODE SET command follows `T_RFC` cycles after the last refresh.
- R6: During MODE SET, `addr_o` = {MODE_OPT[6:0] on bits 13..7, CAS_LAT[2:0] on bits 6..4, WRAP_IL on bit 3, BURST[2:0] on bits 2..0}.
- R7: After MODE SET, exactly `T_MRD` NOP cycles pass with `ready_o` low. Then `ready_o` goes high and stays high, with NOP on the command pins.
- R8: Asserting `rst_ni` at any point forces NOP and `ready_o` low at once. After release, the whole sequence restarts from R1.
- R9: `cke_o` is 1 and `ba_o` is 0 in every cycle. `addr_o` is 0 in every NOP and REFRESH cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Active-low asynchronous reset; restarts the sequence |
| cke_o | output | 1 | Clock enable to the SDRAM |
| cs_no | output | 1 | Chip select, active low |
| ras_no | output | 1 | Row strobe, active low |
| cas_no | output | 1 | Column strobe, active low |
| we_no | output | 1 | Write enable, active low |
| addr_o | output | 14 | Address bus; carries A10 for precharge-all and the mode word |
| ba_o | output | 2 | Bank address |
| ready_o | output | 1 | High once initialization has completed |

## Verification
A wrong count or a wrong transition in the state machine shows on the command pins within a single cycle. A misloaded timer moves the next PRECHARGE, REFRESH or MODE SET by one or more cycles. A refresh counter that is off by one adds or drops a REFRESH and shifts the MODE SET by `T_RFC` cycles. A broken done state shows as `ready_o` rising early, rising late or dropping. The bench decodes the pins in every cycle against an arithmetic timeline, so any of these faults is reported in the first cycle where it occurs.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

  typedef enum logic [3:0] {
    CMD_MRS = 4'b0000,
    CMD_REF = 4'b0001,
    CMD_PRE = 4'b0010,
    CMD_NOP = 4'b0111
  } cmd_e;

  typedef enum logic [2:0] {
    ST_WAIT,
    ST_PRE,
    ST_TRP,
    ST_REF,
    ST_TRFC,
    ST_MRS,
    ST_TMRD,
    ST_DONE
  } st_e;

  function automatic logic [13:0] mode_word(logic [6:0] opt, logic [2:0] cl,
                                            logic wrap, logic [2:0] bl);
    return {opt, cl, wrap, bl};
  endfunction

endpackage

// File: rtl/sdram_gap_timer.sv
module sdram_gap_timer #(
  parameter int CNT_W   = 16,
  parameter int RST_VAL = 0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             zero_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= CNT_W'(RST_VAL);
    else if (load_i)        cnt_q <= load_val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

  // an expired gap stays expired until reloaded (R3)
  assert_zero_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (zero_o && !load_i) |=> zero_o);

endmodule

// File: rtl/sdram_cmd_drive.sv
module sdram_cmd_drive
  import sdram_init_pkg::*;
#(
  parameter logic [13:0] MODE_WORD = 14'h0
) (
  input  st_e         state_i,
  output logic        cke_o,
  output logic        cs_no,
  output logic        ras_no,
  output logic        cas_no,
  output logic        we_no,
  output logic [13:0] addr_o,
  output logic [1:0]  ba_o
);

  cmd_e cmd;

  always_comb begin
    cmd    = CMD_NOP;
    addr_o = '0;
    unique case (state_i)
      ST_PRE: begin cmd = CMD_PRE; addr_o = 14'h0400; end
      ST_REF: cmd = CMD_REF;
      ST_MRS: begin cmd = CMD_MRS; addr_o = MODE_WORD; end
      default: ;
    endcase
  end

  assign {cs_no, ras_no, cas_no, we_no} = cmd;
  assign cke_o = 1'b1;
  assign ba_o  = '0;

endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
  import sdram_init_pkg::*;
#(
  parameter int         CLK_MHZ  = 100,
  parameter int         WAIT_US  = 200,
  parameter int         N_REF    = 8,
  parameter int         T_RP     = 3,
  parameter int         T_RFC    = 8,
  parameter int         T_MRD    = 2,
  parameter logic [6:0] MODE_OPT = 7'd0,
  parameter logic [2:0] CAS_LAT  = 3'd3,
  parameter logic       WRAP_IL  = 1'b0,
  parameter logic [2:0] BURST    = 3'd3
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  output logic        cke_o,
  output logic        cs_no,
  output logic        ras_no,
  output logic        cas_no,
  output logic        we_no,
  output logic [13:0] addr_o,
  output logic [1:0]  ba_o,
  output logic        ready_o
);

  localparam int WAIT_CYC  = CLK_MHZ * WAIT_US;
  localparam int GAP_MAX   = (T_RFC > T_RP) ? ((T_RFC > T_MRD) ? T_RFC : T_MRD)
                                            : ((T_RP > T_MRD) ? T_RP : T_MRD);
  localparam int CNT_MAX   = (WAIT_CYC > GAP_MAX) ? WAIT_CYC : GAP_MAX;
  localparam int CNT_W     = $clog2(CNT_MAX + 1);
  localparam int REF_W     = $clog2(N_REF + 1);
  localparam logic [13:0] MODE_WORD = mode_word(MODE_OPT, CAS_LAT, WRAP_IL, BURST);

  st_e              state_q, state_d;
  logic [REF_W-1:0] ref_cnt_q;
  logic             gap_done;
  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;

  // gap reload on leaving each command state
  always_comb begin
    tmr_load = 1'b1;
    unique case (state_q)
      ST_PRE:  tmr_val = CNT_W'(T_RP - 2);
      ST_REF:  tmr_val = CNT_W'(T_RFC - 2);
      ST_MRS:  tmr_val = CNT_W'(T_MRD - 1);
      default: begin tmr_val = '0; tmr_load = 1'b0; end
    endcase
  end

  sdram_gap_timer #(
    .CNT_W  (CNT_W),
    .RST_VAL(WAIT_CYC - 1)
  ) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (tmr_load),
    .load_val_i(tmr_val),
    .zero_o    (gap_done)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_WAIT: if (gap_done) state_d = ST_PRE;
      ST_PRE:  state_d = ST_TRP;
      ST_TRP:  if (gap_done) state_d = ST_REF;
      ST_REF:  state_d = ST_TRFC;
      ST_TRFC: if (gap_done) state_d = (ref_cnt_q == REF_W'(N_REF)) ? ST_MRS : ST_REF;
      ST_MRS:  state_d = ST_TMRD;
      ST_TMRD: if (gap_done) state_d = ST_DONE;
      ST_DONE: state_d = ST_DONE;
      default: state_d = ST_WAIT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_WAIT;
      ref_cnt_q <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_REF) ref_cnt_q <= ref_cnt_q + 1'b1;
    end
  end

  sdram_cmd_drive #(
    .MODE_WORD(MODE_WORD)
  ) u_drive (
    .state_i(state_q),
    .cke_o  (cke_o),
    .cs_no  (cs_no),
    .ras_no (ras_no),
    .cas_no (cas_no),
    .we_no  (we_no),
    .addr_o (addr_o),
    .ba_o   (ba_o)
  );

  assign ready_o = (state_q == ST_DONE);

  logic [3:0] cmd_pins;
  assign cmd_pins = {cs_no, ras_no, cas_no, we_no};

  assert_pre_all_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_pins == CMD_PRE) |-> addr_o[10]);

  assert_ref_gap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_pins == CMD_REF) |=> (cmd_pins == CMD_NOP));

  assert_ref_total_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_pins == CMD_MRS) |-> (ref_cnt_q == REF_W'(N_REF)));

  assert_mode_word_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_pins == CMD_MRS) |-> (addr_o == MODE_WORD));

  assert_mrs_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_pins == CMD_MRS) |=> (cmd_pins == CMD_NOP && !ready_o));

  assert_ready_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> ready_o);

  assert_ready_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (cmd_pins == CMD_NOP));

endmodule

// File: tb/tb_sdram_init_seq.sv
module tb_sdram_init_seq;

  localparam int CLK_PERIOD = 10;
  localparam int CLK_MHZ = 2;
  localparam int WAIT_US = 200;
  localparam int W       = CLK_MHZ * WAIT_US;
  localparam int N_REF   = 8;
  localparam int T_RP    = 3;
  localparam int T_RFC   = 6;
  localparam int T_MRD   = 2;
  localparam logic [13:0] EXP_MODE = 14'h002B; // opt 0, CL 2, wrap 1, BL code 3
  localparam int SEQ_LEN = W + T_RP + N_REF * T_RFC + T_MRD + 1;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic cke, cs_n, ras_n, cas_n, we_n, rdy;
  logic [13:0] addr;
  logic [1:0]  ba;

  int errors = 0;
  int checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdram_init_seq #(
    .CLK_MHZ(CLK_MHZ), .WAIT_US(WAIT_US), .N_REF(N_REF), .T_RP(T_RP),
    .T_RFC(T_RFC), .T_MRD(T_MRD), .MODE_OPT(7'd0), .CAS_LAT(3'd2),
    .WRAP_IL(1'b1), .BURST(3'd3)
  ) dut (
    .clk_i(clk), .rst_ni(rst_ni), .cke_o(cke), .cs_no(cs_n), .ras_no(ras_n),
    .cas_no(cas_n), .we_no(we_n), .addr_o(addr), .ba_o(ba), .ready_o(rdy)
  );

  // expected command at sample k after reset release: 0 NOP, 1 PRE, 2 REF, 3 MRS
  function automatic int exp_kind(int k);
    int j;
    if (k < W) return 0;
    if (k == W) return 1;
    j = k - W - T_RP;
    if (j < 0) return 0;
    if (j < N_REF * T_RFC) return (j % T_RFC == 0) ? 2 : 0;
    return (j == N_REF * T_RFC) ? 3 : 0;
  endfunction

  function automatic string req_of(int k);
    int j;
    if (k < W) return "R1";
    if (k == W) return "R2";
    j = k - W - T_RP;
    if (j < 0) return "R3";
    if (j < N_REF * T_RFC) return "R4";
    if (j == N_REF * T_RFC) return "R5";
    return "R7";
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_cycle(int k);
    int kind;
    logic [3:0] exp_pins;
    logic [13:0] exp_addr;
    string rq;
    kind = exp_kind(k);
    rq = req_of(k);
    case (kind)
      1: begin exp_pins = 4'b0010; exp_addr = 14'h0400; end
      2: begin exp_pins = 4'b0001; exp_addr = 14'h0; end
      3: begin exp_pins = 4'b0000; exp_addr = EXP_MODE; end
      default: begin exp_pins = 4'b0111; exp_addr = 14'h0; end
    endcase
    check(rq, int'({cs_n, ras_n, cas_n, we_n}), int'(exp_pins));
    if (kind == 3) check("R6", int'(addr), int'(exp_addr));
    else           check("R9", int'(addr), int'(exp_addr));
    check("R9", int'({cke, ba}), 4);
    check((k >= W + T_RP + N_REF * T_RFC) ? "R7" : rq, int'(rdy),
          (k >= SEQ_LEN) ? 1 : 0);
  endtask

  task automatic run(int n);
    for (int k = 0; k < n; k++) begin
      #1 check_cycle(k);
      @(negedge clk);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 check("R8", int'({cs_n, ras_n, cas_n, we_n, rdy}), 5'b01110);
    @(negedge clk);
    rst_ni = 1'b1;
    // partial run, then reset mid-refresh
    run(W + T_RP + 2 * T_RFC + 1);
    rst_ni = 1'b0;
    for (int i = 0; i < 3; i++) begin
      #1 check("R8", int'({cs_n, ras_n, cas_n, we_n, rdy}), 5'b01110);
      @(negedge clk);
    end
    rst_ni = 1'b1;
    // full restart, plus idle cycles after ready
    run(SEQ_LEN + 20);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule